// File: doc/BRIEF.md
# Burst Read Target for a Multiplexed Parallel Bus

This block is the responding side of a synchronous parallel bus where address and data share one set of lines and all handshakes are active low. An initiator opens a transaction by pulling a transaction strobe low. The first cycle of that strobe is the address phase. In it, the shared lines carry a byte address and a 4-bit command code. If the command is a memory read and the address falls inside the block's window, the block claims the transaction. It then returns words from a small internal word store, one word per data phase, until the initiator ends the burst.

The data path works like a stream. The target's ready strobe acts as "valid", and the initiator's ready strobe acts as "ready". A word moves only in a cycle where both strobes are low. Either side can apply back-pressure. When the initiator is not ready, the target holds its word steady. When the store behind the target is not ready, the target withdraws its strobe. A back-end `store_rdy` input models a slow memory.

Tri-state lines are modelled as a value port plus an enable port for each driven signal. The window size in words must be a power of two.

Top module: `burst_read_target`

## Requirements
- R1: While reset is held, and after it is released, all three enables (`adb_oe`, `srdy_oe`, `sel_oe`) are low and `srdy_n`, `sel_n` read high.
- R2: An address phase is a cycle with `txn_n` low that follows a cycle in which both `txn_n` and `mrdy_n` were high. Later cycles of the same strobe are never decoded as addresses, whatever the lines carry.
- R3: An address phase with `cmd_be_n` = 4'b0110 (memory read) and a byte address A where BASE <= A < BASE + 4*WORDS is claimed. In the next cycle, the turnaround cycle, `sel_oe`=1, `sel_n`=0, `srdy_oe`=1 and `adb_oe`=1, and `srdy_n` is high, so no word moves in that cycle.
- R4: Any other command, or an address outside the window, leaves all three enables low for the whole transaction.
- R5: A word moves only in a cycle with `srdy_n` and `mrdy_n` both low. The first word is word index (A-BASE)>>2. Each completed data phase advances the index by one (4 bytes), wrapping modulo WORDS. Word i holds SEED + i*STRIDE.
- R6: If `srdy_n` is low and `mrdy_n` is high in a cycle, the next cycle shows `srdy_n` low and the same value on `adb_o`.
- R7: If the target needs a new word (its strobe is high, or a non-final word just moved) and `store_rdy` is low in that cycle, then `srdy_n` is high in the next cycle. It resumes later with the next unsent word.
- R8: The data phase in which `txn_n` is high is the final one. In the cycle after that word moves, all three enables are low and `sel_n` is high.
- R9: `sel_n` stays low with `sel_oe` high from the turnaround cycle until the final word moves. `srdy_n` is never driven low without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling and driving on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_n | input | 1 | Transaction strobe from the initiator, active low |
| mrdy_n | input | 1 | Initiator ready, active low |
| cmd_be_n | input | 4 | Command in the address phase, byte enables after it |
| adb_i | input | 32 | Shared address/data lines as seen by the target |
| store_rdy | input | 1 | Back-end store can supply a word this cycle |
| adb_o | output | 32 | Data value driven onto the shared lines |
| adb_oe | output | 1 | Drive enable for `adb_o` |
| srdy_n | output | 1 | Target ready value, active low |
| srdy_oe | output | 1 | Drive enable for `srdy_n` |
| sel_n | output | 1 | Claim strobe value, active low |
| sel_oe | output | 1 | Drive enable for `sel_n` |

## Verification
The main read path is swept over every start word in the window and burst lengths of one to four words. Four wait patterns are used:
- No waits, which isolates the claim, turnaround and word order.
- Initiator waits only, which tests holding a word apart from advancing past it.
- Store waits only, which shows whether a withdrawn strobe resumes with the next unsent word rather than repeating or skipping one.
- Both kinds of wait interleaved.

A long burst that starts near the top of the window checks the wrap of the index. Rejected commands and out-of-window addresses check the silent miss path. A foreign transaction whose data cycles carry an in-window memory-read pattern shows that only the first cycle of a strobe is ever decoded.

// File: rtl/brt_pkg.sv
`timescale 1ns/1ps
package brt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TURN = 2'd1,
    ST_DATA = 2'd2
  } brt_state_e;

  localparam logic [3:0] CMD_MEM_READ = 4'b0110;
endpackage

// File: rtl/brt_addr_decode.sv
`timescale 1ns/1ps
module brt_addr_decode #(
  parameter int unsigned W         = 32,
  parameter int unsigned WORDS     = 16,
  parameter logic [W-1:0] BASE_ADDR = '0,
  localparam int unsigned IW       = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          txn_n,
  input  logic          mrdy_n,
  input  logic [3:0]    cmd_be_n,
  input  logic [W-1:0]  adb_i,
  output logic          addr_phase,
  output logic          hit,
  output logic [IW-1:0] start_idx
);
  import brt_pkg::*;

  localparam int unsigned WIN_BYTES = WORDS * 4;
  localparam logic [W:0]  LIMIT     = {1'b0, BASE_ADDR} + (W+1)'(WIN_BYTES);

  logic txn_q, mrdy_q;
  logic in_win;

  // Bus-idle history: an address phase needs an idle cycle before it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txn_q  <= 1'b1;
      mrdy_q <= 1'b1;
    end else begin
      txn_q  <= txn_n;
      mrdy_q <= mrdy_n;
    end
  end

  assign addr_phase = !txn_n && txn_q && mrdy_q;
  assign in_win     = ({1'b0, adb_i} >= {1'b0, BASE_ADDR}) && ({1'b0, adb_i} < LIMIT);
  assign hit        = in_win && (cmd_be_n == CMD_MEM_READ);
  assign start_idx  = IW'((adb_i - BASE_ADDR) >> 2);
endmodule

// File: rtl/brt_word_store.sv
`timescale 1ns/1ps
module brt_word_store #(
  parameter int unsigned W      = 32,
  parameter int unsigned WORDS  = 16,
  parameter logic [W-1:0] SEED   = '0,
  parameter logic [W-1:0] STRIDE = '0,
  localparam int unsigned IW    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic [IW-1:0] idx_i,
  output logic [W-1:0]  word_o
);
  logic [W-1:0] cells [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_cell
    assign cells[g] = SEED + W'(g) * STRIDE;
  end

  assign word_o = cells[idx_i];
endmodule

// File: rtl/brt_phase_ctrl.sv
`timescale 1ns/1ps
module brt_phase_ctrl #(
  parameter int unsigned W     = 32,
  parameter int unsigned WORDS = 16,
  localparam int unsigned IW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          txn_n,
  input  logic          mrdy_n,
  input  logic          store_rdy,
  input  logic          addr_phase,
  input  logic          hit,
  input  logic [IW-1:0] start_idx,
  input  logic [W-1:0]  word_i,
  output logic [IW-1:0] idx_o,
  output logic [W-1:0]  adb_o,
  output logic          adb_oe,
  output logic          srdy_n,
  output logic          srdy_oe,
  output logic          sel_n,
  output logic          sel_oe
);
  import brt_pkg::*;

  brt_state_e    st;
  logic [IW-1:0] idx;
  logic          xfer, last_xfer, init_wait, need_word;
  logic [IW-1:0] idx_next;

  assign xfer      = (st == ST_DATA) && !srdy_n && !mrdy_n;
  assign last_xfer = xfer && txn_n;
  assign init_wait = (st == ST_DATA) && !srdy_n && mrdy_n;
  assign need_word = (st != ST_IDLE) && !last_xfer && !init_wait;
  assign idx_next  = (idx == IW'(WORDS - 1)) ? '0 : idx + 1'b1;
  assign idx_o     = idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      idx     <= '0;
      adb_o   <= '0;
      adb_oe  <= 1'b0;
      srdy_n  <= 1'b1;
      srdy_oe <= 1'b0;
      sel_n   <= 1'b1;
      sel_oe  <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (addr_phase && hit) begin
            st      <= ST_TURN;
            idx     <= start_idx;
            sel_n   <= 1'b0;
            sel_oe  <= 1'b1;
            srdy_n  <= 1'b1;
            srdy_oe <= 1'b1;
            adb_oe  <= 1'b1;
          end
        end
        ST_TURN, ST_DATA: begin
          if (last_xfer) begin
            st      <= ST_IDLE;
            sel_n   <= 1'b1;
            sel_oe  <= 1'b0;
            srdy_n  <= 1'b1;
            srdy_oe <= 1'b0;
            adb_oe  <= 1'b0;
          end else if (need_word) begin
            st <= ST_DATA;
            if (store_rdy) begin
              adb_o  <= word_i;
              idx    <= idx_next;
              srdy_n <= 1'b0;
            end else begin
              srdy_n <= 1'b1;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3: the claim cycle carries no data.
  p_turn_no_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_oe) |-> srdy_n);

  // R4: a rejected address phase never claims.
  p_miss_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && addr_phase && !hit) |=> !sel_oe);

  // R6: initiator wait holds the presented word.
  p_hold_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (srdy_oe && !srdy_n && mrdy_n) |=> (!srdy_n && $stable(adb_o)));

  // R7: store not ready while a word is needed withdraws the strobe.
  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_oe && (srdy_n || (!mrdy_n && !txn_n)) && !store_rdy) |=> srdy_n);

  // R8: release after the final word.
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (srdy_oe && !srdy_n && !mrdy_n && txn_n) |=> (!sel_oe && !srdy_oe && !adb_oe && sel_n));

  // R9: target ready only under an active claim.
  p_sel_covers_rdy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (srdy_oe && !srdy_n) |-> (sel_oe && !sel_n));
endmodule

// File: rtl/burst_read_target.sv
`timescale 1ns/1ps
module burst_read_target #(
  parameter int unsigned  W         = 32,
  parameter int unsigned  WORDS     = 16,
  parameter logic [W-1:0] BASE_ADDR = 32'h0000_2000,
  parameter logic [W-1:0] SEED      = 32'hC3A5_0000,
  parameter logic [W-1:0] STRIDE    = 32'h0001_0111
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         txn_n,
  input  logic         mrdy_n,
  input  logic [3:0]   cmd_be_n,
  input  logic [W-1:0] adb_i,
  input  logic         store_rdy,
  output logic [W-1:0] adb_o,
  output logic         adb_oe,
  output logic         srdy_n,
  output logic         srdy_oe,
  output logic         sel_n,
  output logic         sel_oe
);
  localparam int unsigned IW = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic          addr_phase, hit;
  logic [IW-1:0] start_idx, idx;
  logic [W-1:0]  word;

  brt_addr_decode #(.W(W), .WORDS(WORDS), .BASE_ADDR(BASE_ADDR)) u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .txn_n      (txn_n),
    .mrdy_n     (mrdy_n),
    .cmd_be_n   (cmd_be_n),
    .adb_i      (adb_i),
    .addr_phase (addr_phase),
    .hit        (hit),
    .start_idx  (start_idx)
  );

  brt_word_store #(.W(W), .WORDS(WORDS), .SEED(SEED), .STRIDE(STRIDE)) u_store (
    .idx_i  (idx),
    .word_o (word)
  );

  brt_phase_ctrl #(.W(W), .WORDS(WORDS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .txn_n      (txn_n),
    .mrdy_n     (mrdy_n),
    .store_rdy  (store_rdy),
    .addr_phase (addr_phase),
    .hit        (hit),
    .start_idx  (start_idx),
    .word_i     (word),
    .idx_o      (idx),
    .adb_o      (adb_o),
    .adb_oe     (adb_oe),
    .srdy_n     (srdy_n),
    .srdy_oe    (srdy_oe),
    .sel_n      (sel_n),
    .sel_oe     (sel_oe)
  );
endmodule

// File: tb/burst_read_target_tb.sv
`timescale 1ns/1ps
module burst_read_target_tb;
  localparam logic [31:0] BASE   = 32'h0000_2000;
  localparam logic [31:0] SEED   = 32'hC3A5_0000;
  localparam logic [31:0] STRIDE = 32'h0001_0111;
  localparam int          WORDS  = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        txn_n, mrdy_n, store_rdy;
  logic [3:0]  cmd_be_n;
  logic [31:0] adb_i, adb_o;
  logic        adb_oe, srdy_n, srdy_oe, sel_n, sel_oe;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  burst_read_target u_dut (
    .clk(clk), .rst_n(rst_n), .txn_n(txn_n), .mrdy_n(mrdy_n),
    .cmd_be_n(cmd_be_n), .adb_i(adb_i), .store_rdy(store_rdy),
    .adb_o(adb_o), .adb_oe(adb_oe), .srdy_n(srdy_n), .srdy_oe(srdy_oe),
    .sel_n(sel_n), .sel_oe(sel_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word_at(input int i);
    return SEED + 32'(i % WORDS) * STRIDE;
  endfunction

  function automatic bit init_wait(input int pat, input int c, input int s);
    return pat[0] && (((c * 7 + s) % 3) == 0);
  endfunction

  function automatic bit store_wait(input int pat, input int c, input int s);
    return pat[1] && (((c * 5 + s) % 4) == 1);
  endfunction

  function automatic logic [31:0] oe_bits();
    return {29'd0, adb_oe, srdy_oe, sel_oe};
  endfunction

  task automatic drive_idle();
    txn_n = 1'b1; mrdy_n = 1'b1; cmd_be_n = 4'h0; adb_i = 32'h0; store_rdy = 1'b1;
  endtask

  task automatic run_read(input int start, input int n, input int pat);
    int k = 0;
    bit exp_hold = 0, exp_stall = 0, done = 0, xfer, need;
    logic [31:0] held = '0;
    @(negedge clk);
    txn_n = 1'b0; mrdy_n = 1'b1; adb_i = BASE + 32'(start * 4);
    cmd_be_n = 4'b0110; store_rdy = 1'b1;
    @(negedge clk);
    // R3: turnaround cycle after the claim
    chk(sel_oe && !sel_n && srdy_oe && adb_oe, "R3 claim enables", oe_bits(), 32'h7);
    chk(srdy_n == 1'b1, "R3 no data in turnaround", {31'd0, srdy_n}, 32'h1);
    adb_i = '0; cmd_be_n = '0;
    txn_n = (n == 1);
    mrdy_n = txn_n ? 1'b0 : init_wait(pat, 0, start);
    store_rdy = !store_wait(pat, 0, start);
    exp_stall = !store_rdy;
    for (int c = 1; c < 300 && !done; c++) begin
      @(negedge clk);
      // R9: claim held throughout
      chk(sel_oe && !sel_n, "R9 claim held", {30'd0, sel_oe, sel_n}, 32'h2);
      if (exp_stall) chk(srdy_n == 1'b1, "R7 strobe withdrawn", {31'd0, srdy_n}, 32'h1);
      if (exp_hold) chk(!srdy_n && adb_o == held, "R6 word held", adb_o, held);
      if (!srdy_n) chk(adb_o == word_at(start + k), "R5 word value", adb_o, word_at(start + k));
      txn_n = (k >= n - 1);
      mrdy_n = txn_n ? 1'b0 : init_wait(pat, c, start);
      store_rdy = !store_wait(pat, c, start);
      xfer = !srdy_n && !mrdy_n;
      exp_hold = !srdy_n && mrdy_n;
      held = adb_o;
      need = srdy_n || (xfer && !txn_n);
      exp_stall = need && !store_rdy;
      if (xfer) begin
        k++;
        if (k == n) done = 1;
      end
    end
    chk(done, "R5 burst completed", 32'(k), 32'(n));
    @(negedge clk);
    // R8: release after the final word
    chk(!sel_oe && !srdy_oe && !adb_oe && sel_n, "R8 release", {28'd0, sel_n, oe_bits()[2:0]}, 32'h8);
    drive_idle();
  endtask

  task automatic run_miss(input logic [31:0] addr, input logic [3:0] cmd, input string req);
    @(negedge clk);
    txn_n = 1'b0; mrdy_n = 1'b1; adb_i = addr; cmd_be_n = cmd;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(oe_bits() == 32'h0, req, oe_bits(), 32'h0);
      // data cycles carry an in-window memory-read pattern (R2)
      txn_n = (i >= 2); mrdy_n = 1'b0; adb_i = BASE + 32'h8; cmd_be_n = 4'b0110;
    end
    @(negedge clk);
    chk(oe_bits() == 32'h0, req, oe_bits(), 32'h0);
    drive_idle();
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive_idle();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(oe_bits() == 32'h0 && srdy_n && sel_n, "R1 reset outputs", {28'd0, srdy_n, sel_n, adb_oe, srdy_oe | sel_oe}, 32'hC);
    rst_n = 1'b1;
    @(negedge clk);
    chk(oe_bits() == 32'h0 && srdy_n && sel_n, "R1 after reset", oe_bits(), 32'h0);

    // R4: rejected commands and addresses
    run_miss(BASE, 4'b0010, "R4 io read ignored");
    run_miss(BASE, 4'b0111, "R4 mem write ignored");
    run_miss(BASE - 32'h4, 4'b0110, "R4 below window");
    run_miss(BASE + 32'(WORDS * 4), 4'b0110, "R4 above window");
    // R2: foreign transaction whose data cycles look like a hit
    run_miss(32'h0000_0040, 4'b0110, "R2 data cycles not decoded");
    run_read(3, 2, 0);

    for (int pat = 0; pat < 4; pat++)
      for (int s = 0; s < WORDS; s++)
        for (int n = 1; n <= 4; n++)
          run_read(s, n, pat);

    // R5: long bursts wrapping the index
    run_read(WORDS - 3, 20, 3);
    run_read(WORDS - 1, 18, 0);

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule